// File: doc/BRIEF.md
# Host Interrupt Status Aggregator

This block gathers interrupt events from the on-chip sources that report to the host: four bus-master DMA channels, four mailboxes, two wake-up sources and two bus abort detectors. It merges them into one 16-bit sticky status register and drives a single active-low host interrupt line. Software clears serviced bits by writing ones to them.

Each DMA channel does not raise its bit on every transfer. A per-channel pacing counter counts down one step per transfer-completion pulse. When it reaches zero it raises the channel's bit and reloads itself from a programmable base count. This lets software choose how many transfers pass between interrupts. A base count of zero silences a channel.

The sources arrive as single-cycle pulses. Software reaches the status register, the base counts and the live counts through a simple synchronous write port and a combinational read port.

Top module: `host_irq_aggregator`

## Requirements
- R1: After reset the status register reads 0, `intaN` is 1, and every channel's base count and live count equal the parameter `RESET_BASE`.
- R2: With a non-zero base count B on a channel, every Bth completion pulse on that channel sets its status bit. The DMA channels 0..3 use status bits 1..4. The live count steps B, B-1, ..., 1 and then reloads to B on the pulse that sets the bit.
- R3: `intaN` is 0 exactly when at least one status bit is 1.
- R4: A write to address 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R5: When a source sets a bit in the same cycle that a write to address 0 clears it, the bit ends up set.
- R6: Status bits 0, 9, 10 and 15 always read 0, whatever is written or pulsed.
- R7: The other sources set these status bits: incoming mailbox 0 and 1 set bits 5 and 6, outgoing mailbox 0 and 1 set bits 7 and 8, the I/O wake-up sets bit 11, the AC'97 wake-up sets bit 12, the master abort sets bit 13 and the target abort sets bit 14.
- R8: A write to address 1+c loads channel c's base count and its live count with the written value. If a completion pulse for that channel arrives in the same cycle, the write takes effect and the pulse is dropped, with no decrement and no interrupt.
- R9: A channel whose base count is 0 never sets its status bit, and its live count stays 0.
- R10: The read map is as follows. Address 0 returns the status, addresses 1..4 return the base counts of channels 0..3, and addresses 5..8 return the live counts of channels 0..3. All other addresses read 0. Writes to addresses other than 0..4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address for read and write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Combinational read data for `regAddr` |
| dmaDone | input | 4 | Per-channel DMA transfer-completion pulses |
| mboxInEvt | input | 2 | Incoming mailbox event pulses |
| mboxOutEvt | input | 2 | Outgoing mailbox event pulses |
| ioWakeEvt | input | 1 | I/O-pin wake-up pulse |
| acWakeEvt | input | 1 | AC'97 wake-up pulse |
| mAbortEvt | input | 1 | Master abort detected pulse |
| tAbortEvt | input | 1 | Target abort detected pulse |
| intaN | output | 1 | Active-low shared host interrupt |

## Verification
Two collisions can fall in the same cycle. The first is a source setting a status bit while software write-1-clears it. The second is a DMA completion pulse arriving while software rewrites that channel's base count. The bench provokes both by driving the event pulse and the register write on the same falling edge. It then judges the outcome at the next falling edge: the status bit must remain set, and the live count must equal the newly written base with no interrupt raised. Sweeps over small base counts also confirm the interrupt spacing arithmetically.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_DMA = 4;
  localparam int STAT_W = 16;
  // Bits that a source can set; all others are reserved and stay 0.
  localparam logic [STAT_W-1:0] IMPL_MASK = 16'h79FE;
  localparam int DMA_LSB = 1;
  localparam int MBOX_IN_LSB = 5;
  localparam int MBOX_OUT_LSB = 7;
  localparam int IOWAKE_BIT = 11;
  localparam int ACWAKE_BIT = 12;
  localparam int MABORT_BIT = 13;
  localparam int TABORT_BIT = 14;

  typedef struct packed {
    logic [NUM_DMA-1:0] chanFire;  // pacing counter reached zero
    logic [STAT_W-1:0]  clrMask;   // write-1-to-clear mask from software
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_chan_pacer.sv
module irq_chan_pacer #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RESET_BASE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baseWrEn,
  input  logic [CNT_W-1:0] baseWrData,
  input  logic             donePulse,
  output logic             fire,
  output logic [CNT_W-1:0] baseVal,
  output logic [CNT_W-1:0] cntVal
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic enabled;
  assign enabled = (baseVal != '0);
  // A register write takes priority over a completion pulse.
  assign fire = donePulse && !baseWrEn && enabled && (cntVal == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseVal <= RESET_BASE;
      cntVal  <= RESET_BASE;
    end else if (baseWrEn) begin
      baseVal <= baseWrData;
      cntVal  <= baseWrData;
    end else if (donePulse && enabled) begin
      if (cntVal == ONE) cntVal <= baseVal;
      else               cntVal <= cntVal - ONE;
    end
  end

  AST_FIRE_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> (cntVal == $past(baseVal)));                            // R2
  AST_LIVE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (baseVal != '0) |-> (cntVal != '0));                             // R2
  AST_BASE_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (baseVal == '0) |-> !fire);                                      // R9
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |=> (cntVal == $past(baseWrData) && baseVal == $past(baseWrData))); // R8
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ADDR_W = 4,
  parameter logic [CNT_W-1:0] RESET_BASE = 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWrEn,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic [STAT_W-1:0]                 regWrData,
  input  logic [NUM_DMA-1:0]                dmaDone,
  output ctrlStrobe_t                       strobes,
  output logic [NUM_DMA-1:0][CNT_W-1:0]     baseVals,
  output logic [NUM_DMA-1:0][CNT_W-1:0]     cntVals
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = '0;

  logic statusWr;
  assign statusWr = regWrEn && (regAddr == STATUS_ADDR);
  assign strobes.clrMask = statusWr ? regWrData : '0;

  for (genvar c = 0; c < NUM_DMA; c++) begin : gChan
    logic baseWr;
    assign baseWr = regWrEn && (regAddr == ADDR_W'(1 + c));
    irq_chan_pacer #(.CNT_W(CNT_W), .RESET_BASE(RESET_BASE)) uPacer (
      .clk       (clk),
      .rstN      (rstN),
      .baseWrEn  (baseWr),
      .baseWrData(regWrData[CNT_W-1:0]),
      .donePulse (dmaDone[c]),
      .fire      (strobes.chanFire[c]),
      .baseVal   (baseVals[c]),
      .cntVal    (cntVals[c])
    );
  end

  AST_FIRE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.chanFire & ~dmaDone) == '0));                          // R2
endmodule

// File: rtl/irq_agg_dpath.sv
module irq_agg_dpath
  import irq_agg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobes,
  input  logic [1:0]                    mboxInEvt,
  input  logic [1:0]                    mboxOutEvt,
  input  logic                          ioWakeEvt,
  input  logic                          acWakeEvt,
  input  logic                          mAbortEvt,
  input  logic                          tAbortEvt,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [NUM_DMA-1:0][CNT_W-1:0] baseVals,
  input  logic [NUM_DMA-1:0][CNT_W-1:0] cntVals,
  output logic [STAT_W-1:0]             regRdData,
  output logic                          intaN
);
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] setVec;

  always_comb begin
    setVec = '0;
    setVec[DMA_LSB +: NUM_DMA] = strobes.chanFire;
    setVec[MBOX_IN_LSB +: 2]   = mboxInEvt;
    setVec[MBOX_OUT_LSB +: 2]  = mboxOutEvt;
    setVec[IOWAKE_BIT]         = ioWakeEvt;
    setVec[ACWAKE_BIT]         = acWakeEvt;
    setVec[MABORT_BIT]         = mAbortEvt;
    setVec[TABORT_BIT]         = tAbortEvt;
  end

  // Clear first, then set: a same-cycle set survives the clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= ((status & ~strobes.clrMask) | setVec) & IMPL_MASK;
  end

  assign intaN = ~(|status);

  always_comb begin
    regRdData = '0;
    if (regAddr == '0) regRdData = status;
    for (int c = 0; c < NUM_DMA; c++) begin
      if (regAddr == ADDR_W'(1 + c))           regRdData = STAT_W'(baseVals[c]);
      if (regAddr == ADDR_W'(1 + NUM_DMA + c)) regRdData = STAT_W'(cntVals[c]);
    end
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((status & $past(strobes.clrMask & ~setVec)) == '0));   // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((status & $past(setVec & IMPL_MASK)) == $past(setVec & IMPL_MASK))); // R5
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((status & $past(status & ~strobes.clrMask)) == $past(status & ~strobes.clrMask))); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~IMPL_MASK) == '0));                                  // R6
  AST_INTA_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intaN) |-> $past(|setVec));                                // R3
endmodule

// File: rtl/host_irq_aggregator.sv
module host_irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int CNT_W = 16,      // at most 16
  parameter int ADDR_W = 4,
  parameter logic [CNT_W-1:0] RESET_BASE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic [3:0]        dmaDone,
  input  logic [1:0]        mboxInEvt,
  input  logic [1:0]        mboxOutEvt,
  input  logic              ioWakeEvt,
  input  logic              acWakeEvt,
  input  logic              mAbortEvt,
  input  logic              tAbortEvt,
  output logic              intaN
);
  ctrlStrobe_t                   strobes;
  logic [NUM_DMA-1:0][CNT_W-1:0] baseVals;
  logic [NUM_DMA-1:0][CNT_W-1:0] cntVals;

  irq_agg_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .RESET_BASE(RESET_BASE)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .dmaDone  (dmaDone),
    .strobes  (strobes),
    .baseVals (baseVals),
    .cntVals  (cntVals)
  );

  irq_agg_dpath #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .mboxInEvt (mboxInEvt),
    .mboxOutEvt(mboxOutEvt),
    .ioWakeEvt (ioWakeEvt),
    .acWakeEvt (acWakeEvt),
    .mAbortEvt (mAbortEvt),
    .tAbortEvt (tAbortEvt),
    .regAddr   (regAddr),
    .baseVals  (baseVals),
    .cntVals   (cntVals),
    .regRdData (regRdData),
    .intaN     (intaN)
  );
endmodule

// File: tb/sim_host_irq_aggregator.sv
`timescale 1ns/1ps
module sim_host_irq_aggregator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [3:0]  dmaDone = '0;
  logic [1:0]  mboxInEvt = '0;
  logic [1:0]  mboxOutEvt = '0;
  logic        ioWakeEvt = 1'b0, acWakeEvt = 1'b0, mAbortEvt = 1'b0, tAbortEvt = 1'b0;
  logic        intaN;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  host_irq_aggregator #(.CNT_W(16), .ADDR_W(4), .RESET_BASE(16'd1)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dmaDone(dmaDone),
    .mboxInEvt(mboxInEvt), .mboxOutEvt(mboxOutEvt), .ioWakeEvt(ioWakeEvt),
    .acWakeEvt(acWakeEvt), .mAbortEvt(mAbortEvt), .tAbortEvt(tAbortEvt),
    .intaN(intaN)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic readReg(input int a, output int v);
    regAddr = 4'(a);
    #0.5;
    v = int'(regRdData);
  endtask

  task automatic writeReg(input int a, input int d);
    regWrEn = 1'b1; regAddr = 4'(a); regWrData = 16'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic clearEvents();
    dmaDone = '0; mboxInEvt = '0; mboxOutEvt = '0;
    ioWakeEvt = 0; acWakeEvt = 0; mAbortEvt = 0; tAbortEvt = 0;
  endtask

  initial begin
    int v;
    int expStat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(0, v); check("R1 status", v, 0);
    check("R1 intaN", int'(intaN), 1);
    for (int c = 0; c < 4; c++) begin
      readReg(1 + c, v); check("R1 base", v, 1);
      readReg(5 + c, v); check("R1 count", v, 1);
    end

    // R2 / R3 sweep of base counts per channel
    for (int c = 0; c < 4; c++) begin
      for (int b = 1; b <= 4; b++) begin
        writeReg(1 + c, b);
        writeReg(0, 16'hFFFF);
        for (int p = 1; p <= 2 * b + 1; p++) begin
          dmaDone[c] = 1'b1;
          @(negedge clk);
          dmaDone = '0;
          readReg(0, v);
          check("R2 dma bit", v, (p % b == 0) ? (1 << (1 + c)) : 0);
          check("R3 intaN", int'(intaN), (p % b == 0) ? 0 : 1);
          readReg(5 + c, v);
          check("R2 live count", v, b - (p % b));
          if (p % b == 0) writeReg(0, 1 << (1 + c));
        end
      end
    end

    // R9 base zero silences the channel
    writeReg(3, 0);
    for (int p = 0; p < 3; p++) begin
      dmaDone[2] = 1'b1; @(negedge clk); dmaDone = '0;
    end
    readReg(0, v); check("R9 status", v, 0);
    readReg(7, v); check("R9 live count", v, 0);

    // R8 base write collides with completion pulse
    writeReg(1, 3);
    dmaDone[0] = 1'b1; @(negedge clk); dmaDone = '0;
    readReg(5, v); check("R8 count before", v, 2);
    dmaDone[0] = 1'b1; writeReg(1, 1); dmaDone = '0;
    readReg(5, v); check("R8 write wins count", v, 1);
    readReg(0, v); check("R8 no fire", v, 0);

    // R7 each non-DMA source maps to its bit
    for (int s = 0; s < 8; s++) begin
      int bitPos;
      case (s)
        0: begin mboxInEvt[0] = 1; bitPos = 5; end
        1: begin mboxInEvt[1] = 1; bitPos = 6; end
        2: begin mboxOutEvt[0] = 1; bitPos = 7; end
        3: begin mboxOutEvt[1] = 1; bitPos = 8; end
        4: begin ioWakeEvt = 1; bitPos = 11; end
        5: begin acWakeEvt = 1; bitPos = 12; end
        6: begin mAbortEvt = 1; bitPos = 13; end
        default: begin tAbortEvt = 1; bitPos = 14; end
      endcase
      @(negedge clk);
      clearEvents();
      readReg(0, v); check("R7 source bit", v, 1 << bitPos);
      check("R3 intaN low", int'(intaN), 0);
      writeReg(0, 1 << bitPos);
      readReg(0, v); check("R4 cleared", v, 0);
      check("R3 intaN high", int'(intaN), 1);
    end

    // R6 reserved bits never set, all sources together
    writeReg(1, 1); writeReg(2, 1); writeReg(3, 1); writeReg(4, 1);
    dmaDone = 4'hF; mboxInEvt = 2'b11; mboxOutEvt = 2'b11;
    ioWakeEvt = 1; acWakeEvt = 1; mAbortEvt = 1; tAbortEvt = 1;
    @(negedge clk);
    clearEvents();
    readReg(0, v); check("R6 all sources", v, 16'h79FE);

    // R4 writing zeros keeps, then bit-by-bit clear
    writeReg(0, 0);
    readReg(0, v); check("R4 zero write keeps", v, 16'h79FE);
    expStat = 16'h79FE;
    for (int k = 0; k < 16; k++) begin
      writeReg(0, 1 << k);
      expStat = expStat & ~(1 << k);
      readReg(0, v); check("R4 single clear", v, expStat);
    end

    // R5 set wins against same-cycle clear
    mboxInEvt[0] = 1'b1; tAbortEvt = 1'b1;
    writeReg(0, 16'hFFFF);
    clearEvents();
    readReg(0, v); check("R5 set wins", v, (1 << 5) | (1 << 14));
    writeReg(0, 16'hFFFF);

    // R10 unmapped addresses and ignored writes
    writeReg(2, 5);
    writeReg(6, 9);
    readReg(6, v); check("R10 count write ignored", v, 5);
    readReg(2, v); check("R10 base readback", v, 5);
    for (int a = 9; a < 16; a++) begin
      writeReg(a, 16'hFFFF);
      readReg(a, v); check("R10 unmapped reads 0", v, 0);
    end
    readReg(0, v); check("R10 status untouched", v, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule